// File: doc/BRIEF.md
# Tiled View Address Generator

This block converts a pixel coordinate into a 32-bit address inside a tiled memory aperture. Each request carries the storage format of the surface, a 3-bit view orientation and the x and y coordinates of the pixel. The block applies mirroring to either axis and swaps the axes for the rotated views. It then places the resulting offset in the low address bits and packs the orientation and format codes into the top bits. Alongside the address it returns a flag that says whether the coordinate was in range, and the line stride (in bytes) for the chosen orientation.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream. A single output register sits between them. A request is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result holds steady and no new request is taken. Translation of the address to physical memory and allocation of containers happen elsewhere.

Top module: `tvg_addr_gen`

## Requirements
- R1: Address bits [28:27] carry the format code of the request: 0 is 8-bit tiled, 1 is 16-bit tiled, 2 is 32-bit tiled, 3 is page mode.
- R2: Address bits [31:29] carry the 3-bit orientation code unchanged. Bit 0 of that code inverts y, bit 1 inverts x and bit 2 swaps the axes. This gives 0 = 0°, 1 = 180° mirrored, 2 = 0° mirrored, 3 = 180°, 4 = 270° mirrored, 5 = 270°, 6 = 90°, 7 = 90° mirrored.
- R3: Each format removes coordinate bits through an (x, y) shift of (0,0) for 8-bit, (0,1) for 16-bit and (1,1) for 32-bit. There are 14 − x-shift x bits and 13 − y-shift y bits. The packed offset is shifted left by x-shift + y-shift, so its lowest x-shift + y-shift address bits are zero.
- R4: If x exceeds its all-ones mask, or y exceeds its all-ones mask, the whole address is 0 and `out_ok` is 0. A coordinate equal to its mask is in range.
- R5: When the x-invert bit is set, x is XORed with the x mask. When the y-invert bit is set, y is XORed with the y mask.
- R6: When the swap bit is set, the offset is (x << y_bits) + y. Otherwise it is (y << x_bits) + x. The offset uses the coordinates after mirroring.
- R7: `out_stride` is 1 << (13 + x-shift) when the axes are swapped, and 1 << (14 + y-shift) otherwise. It is valid for in-range and out-of-range requests alike.
- R8: In page mode both shifts are 6, so x has 8 bits, y has 7 bits and the offset is shifted left by 12.
- R9: A result appears on `out_valid` at the edge after the request is accepted. It holds all output fields stable while `out_ready` is low. `in_ready` is low exactly when a result is waiting and `out_ready` is low.
- R10: After reset `out_valid` is 0, `out_addr` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_fmt | input | 2 | Storage format code |
| in_orient | input | 3 | View orientation code |
| in_x | input | 16 | Pixel x coordinate |
| in_y | input | 16 | Pixel y coordinate |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_addr | output | 32 | Aperture address (0 when out of range) |
| out_ok | output | 1 | Coordinate was inside the format's range |
| out_stride | output | 32 | Line stride in bytes for the orientation |

## Verification
A fixed coordinate is sent through all eight orientations. Because the coordinate is asymmetric, a swapped mirror bit or a swapped axis gives a different offset for each code. The same coordinate is then sent through each format, which separates the shift and field placement of the four formats. Coordinates at the mask and one past it are sent on both axes for the narrowest and widest formats, which tests the range comparison at its edges. A long random run with random back-pressure on the output checks ordering and hold behaviour, and a forced stall checks that the result stays steady and that no new request is taken.

// File: rtl/tvg_pkg.sv
package tvg_pkg;
  typedef enum logic [1:0] {
    FMT_T8   = 2'd0,
    FMT_T16  = 2'd1,
    FMT_T32  = 2'd2,
    FMT_PAGE = 2'd3
  } tvg_fmt_e;

  // orientation bit positions
  localparam int unsigned OR_YINV = 0;
  localparam int unsigned OR_XINV = 1;
  localparam int unsigned OR_SWAP = 2;

  typedef struct packed {
    logic [4:0]  xs;     // x shift
    logic [4:0]  ys;     // y shift
    logic [4:0]  xb;     // live x bits
    logic [4:0]  yb;     // live y bits
  } tvg_geom_t;
endpackage

// File: rtl/tvg_geom.sv
module tvg_geom
  import tvg_pkg::*;
#(
  parameter int unsigned CW_BITS     = 14,
  parameter int unsigned CH_BITS     = 13,
  parameter int unsigned SLOT_W_BITS = 6,
  parameter int unsigned SLOT_H_BITS = 6
) (
  input  logic [1:0] fmt,
  output tvg_geom_t  geom
);
  localparam logic [4:0] CWB = 5'(CW_BITS);
  localparam logic [4:0] CHB = 5'(CH_BITS);
  localparam logic [4:0] PXS = 5'(SLOT_W_BITS);
  localparam logic [4:0] PYS = 5'(SLOT_H_BITS);

  logic [4:0] xs, ys;

  always_comb begin
    unique case (tvg_fmt_e'(fmt))
      FMT_T8:   begin xs = 5'd0; ys = 5'd0; end
      FMT_T16:  begin xs = 5'd0; ys = 5'd1; end
      FMT_T32:  begin xs = 5'd1; ys = 5'd1; end
      default:  begin xs = PXS;  ys = PYS;  end
    endcase
  end

  assign geom.xs = xs;
  assign geom.ys = ys;
  assign geom.xb = CWB - xs;
  assign geom.yb = CHB - ys;
endmodule

// File: rtl/tvg_xform.sv
module tvg_xform
  import tvg_pkg::*;
#(
  parameter int unsigned CW_BITS = 14,
  parameter int unsigned CH_BITS = 13,
  parameter int unsigned COORD_W = 16
) (
  input  tvg_geom_t          geom,
  input  logic [2:0]         orient,
  input  logic [1:0]         fmt,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  output logic [31:0]        addr,
  output logic               ok,
  output logic [31:0]        stride
);
  localparam int unsigned OFF_W = CW_BITS + CH_BITS;

  logic [31:0] xw, yw, xm, ym, xi, yi, off, sh;

  always_comb begin
    xw = 32'(x);
    yw = 32'(y);
    xm = (32'd1 << geom.xb) - 32'd1;
    ym = (32'd1 << geom.yb) - 32'd1;
    ok = (xw <= xm) && (yw <= ym);
    xi = orient[OR_XINV] ? (xw ^ xm) : xw;
    yi = orient[OR_YINV] ? (yw ^ ym) : yw;
    if (orient[OR_SWAP]) off = (xi << geom.yb) + yi;
    else                 off = (yi << geom.xb) + xi;
    sh = off << (geom.xs + geom.ys);
    if (ok) addr = {orient, fmt, sh[OFF_W-1:0]};
    else    addr = 32'd0;
    if (orient[OR_SWAP]) stride = 32'd1 << (5'(CH_BITS) + geom.xs);
    else                 stride = 32'd1 << (5'(CW_BITS) + geom.ys);
  end
endmodule

// File: rtl/tvg_addr_gen.sv
module tvg_addr_gen
  import tvg_pkg::*;
#(
  parameter int unsigned CW_BITS     = 14,
  parameter int unsigned CH_BITS     = 13,
  parameter int unsigned SLOT_W_BITS = 6,
  parameter int unsigned SLOT_H_BITS = 6,
  parameter int unsigned COORD_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_fmt,
  input  logic [2:0]         in_orient,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [31:0]        out_addr,
  output logic               out_ok,
  output logic [31:0]        out_stride
);
  tvg_geom_t   geom;
  logic [31:0] c_addr, c_stride;
  logic        c_ok;
  logic        take;

  tvg_geom #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS),
    .SLOT_W_BITS(SLOT_W_BITS), .SLOT_H_BITS(SLOT_H_BITS)
  ) u_geom (
    .fmt  (in_fmt),
    .geom (geom)
  );

  tvg_xform #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .COORD_W(COORD_W)
  ) u_xform (
    .geom   (geom),
    .orient (in_orient),
    .fmt    (in_fmt),
    .x      (in_x),
    .y      (in_y),
    .addr   (c_addr),
    .ok     (c_ok),
    .stride (c_stride)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_addr   <= 32'd0;
      out_ok     <= 1'b0;
      out_stride <= 32'd0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_addr   <= c_addr;
      out_ok     <= c_ok;
      out_stride <= c_stride;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/tvg_addr_gen_chk.sv
module tvg_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [1:0]  in_fmt,
  input logic [2:0]  in_orient,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_addr,
  input logic        out_ok,
  input logic [31:0] out_stride
);
  assert_fmt_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!out_ok || out_addr[28:27] == $past(in_fmt)));

  assert_view_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!out_ok || out_addr[31:29] == $past(in_orient)));

  assert_align_32b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ok && out_addr[28:27] == 2'd2) |-> (out_addr[1:0] == 2'b00));

  assert_range_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ok) |-> (out_addr == 32'd0));

  assert_stride_pow2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_stride) == 1));

  assert_page_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ok && out_addr[28:27] == 2'd3) |-> (out_addr[11:0] == 12'd0));

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_addr) && $stable(out_stride) && $stable(out_ok)));
endmodule

bind tvg_addr_gen tvg_addr_gen_chk u_chk (.*);

// File: tb/tvg_addr_gen_tb.sv
module tvg_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_fmt = '0;
  logic [2:0]  in_orient = '0;
  logic [15:0] in_x = '0;
  logic [15:0] in_y = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic        out_ok;
  logic [31:0] out_stride;

  always #4 clk = ~clk;

  tvg_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fmt(in_fmt), .in_orient(in_orient), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_ok(out_ok), .out_stride(out_stride)
  );

  typedef struct {
    logic [31:0] a;
    logic        ok;
    logic [31:0] st;
    string       tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  int rdy_mode = 0; // 0 always ready, 1 random, 2 stalled
  bit finished = 0;

  task automatic check(input bit cond, input string tag, input longint act, input longint exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input [1:0] f, input [2:0] o, input [15:0] x, input [15:0] y, input string tag);
    exp_t e;
    int xs, ys, xb, yb;
    longint xm, ym, xi, yi, off;
    case (f)
      2'd0: begin xs = 0; ys = 0; end
      2'd1: begin xs = 0; ys = 1; end
      2'd2: begin xs = 1; ys = 1; end
      default: begin xs = 6; ys = 6; end
    endcase
    xb = 14 - xs; yb = 13 - ys;
    xm = (64'd1 << xb) - 1; ym = (64'd1 << yb) - 1;
    e.ok = (x <= xm) && (y <= ym);
    xi = o[1] ? (x ^ xm) : x;
    yi = o[0] ? (y ^ ym) : y;
    off = o[2] ? ((xi << yb) + yi) : ((yi << xb) + xi);
    off = off << (xs + ys);
    e.a = e.ok ? (32'(o) << 29) | (32'(f) << 27) | 32'(off) : 32'd0;
    e.st = o[2] ? (32'd1 << (13 + xs)) : (32'd1 << (14 + ys));
    e.tag = tag;
    return e;
  endfunction

  task automatic send(input [1:0] f, input [2:0] o, input [15:0] x, input [15:0] y, input string tag);
    bit acc;
    q.push_back(model(f, o, x, y, tag));
    @(negedge clk);
    in_valid = 1'b1; in_fmt = f; in_orient = o; in_x = x; in_y = y;
    forever begin
      #2 acc = in_ready;
      @(negedge clk);
      if (acc) break;
    end
    in_valid = 1'b0;
  endtask

  // monitor: sets back-pressure, then scores results that leave this cycle
  initial begin
    forever begin
      @(negedge clk);
      if (rdy_mode == 0) out_ready = 1'b1;
      else if (rdy_mode == 2) out_ready = 1'b0;
      else out_ready = 1'($urandom_range(0, 1));
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R9 unexpected result", out_addr, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(out_addr == e.a, {e.tag, " addr"}, out_addr, e.a);
          check(out_ok == e.ok, {e.tag, " ok"}, out_ok, e.ok);
          check(out_stride == e.st, {"R7 stride ", e.tag}, out_stride, e.st);
        end
      end
    end
  end

  task automatic drain();
    int n = 0;
    while (q.size() != 0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(q.size() == 0, "R9 drain", q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
    check(out_addr == 32'd0, "R10 out_addr", out_addr, 0);
    check(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
    rst_n = 1'b1;

    // R1, R3, R8: same coordinate through each format
    for (int f = 0; f < 4; f++) send(2'(f), 3'd0, 16'd5, 16'd3, "R1 R3 R8 fmt");
    // R2, R5, R6: asymmetric coordinate through every orientation
    for (int o = 0; o < 8; o++) send(2'd0, 3'(o), 16'd100, 16'd7, "R2 R5 R6 orient");
    for (int o = 0; o < 8; o++) send(2'd2, 3'(o), 16'd9, 16'd1234, "R2 R6 orient 32b");
    send(2'd0, 3'd2, 16'd0, 16'd0, "R5 x mirror of 0");
    send(2'd0, 3'd1, 16'd0, 16'd0, "R5 y mirror of 0");
    // R4 boundaries
    send(2'd0, 3'd0, 16'h3FFF, 16'h1FFF, "R4 max in range 8b");
    send(2'd0, 3'd0, 16'h4000, 16'd0, "R4 x over 8b");
    send(2'd0, 3'd0, 16'd0, 16'h2000, "R4 y over 8b");
    send(2'd1, 3'd0, 16'd0, 16'h0FFF, "R4 y at mask 16b");
    send(2'd1, 3'd0, 16'd0, 16'h1000, "R4 y over 16b");
    send(2'd2, 3'd0, 16'h2000, 16'd0, "R4 x over 32b");
    send(2'd3, 3'd7, 16'd255, 16'd127, "R8 page at mask");
    send(2'd3, 3'd0, 16'd256, 16'd0, "R8 R4 page x over");
    send(2'd3, 3'd5, 16'd17, 16'd128, "R8 R4 page y over");
    drain();

    // R9 stall: result must hold and input must be refused
    rdy_mode = 2;
    send(2'd1, 3'd6, 16'd321, 16'd45, "R9 stalled item");
    repeat (3) @(negedge clk);
    #2;
    check(out_valid == 1'b1, "R9 valid held", out_valid, 1);
    check(in_ready == 1'b0, "R9 in_ready low while stalled", in_ready, 0);
    check(out_addr == q[0].a, "R9 addr held", out_addr, q[0].a);
    rdy_mode = 0;
    drain();

    // random run under random back-pressure
    rdy_mode = 1;
    for (int i = 0; i < 300; i++)
      send(2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
           16'($urandom_range(0, 16500)), 16'($urandom_range(0, 8300)), "R3 R6 R9 random");
    rdy_mode = 0;
    drain();

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule